// File: doc/BRIEF.md
# System Address Decoder With Boot Overlay

This block sits between an 8-bit CPU and the memories of a 64 KB address space. For every address the CPU presents, it chooses exactly one target region. The regions are an internal boot ROM, cartridge space, video RAM, external RAM, work RAM, an object-attribute area, the I/O register page and a small high RAM. For the chosen region it produces a local offset inside that region. It forwards writes aimed at cartridge space to the bank controller as command writes. It returns the read data of the chosen region through a one-hot multiplexer.

A flag that is set at reset makes the boot ROM overlay the lowest bytes of cartridge space. A single write to the boot-exit address drops the overlay for good. While the overlay is active, the lowest 4 KB of cartridge space refuses command writes. Work RAM answers a second time in a mirror window above its home window, so both windows share one storage.

The read path has a selectable latency. With the default of one cycle, the region choice and the boot byte are registered, so that they line up with synchronous memories that return data one clock after the address.

Top module: `sysmap_decoder`

## Requirements
- R1: After reset `boot_active` is 1. While it is 1, a read of 0x0000–0x00FF returns boot byte b(i) for offset i, where b(i) = ((37·i + 0x5B) mod 256) XOR (i with its two nibbles swapped).
- R2: `rgn_sel` is one-hot, with bit 0 for boot, 1 for cart, 2 for video RAM, 3 for external RAM, 4 for work RAM, 5 for object attributes, 6 for I/O and 7 for high RAM. While booting, 0x0000–0x00FF selects bit 0. Otherwise every address in 0x0000–0x7FFF selects bit 1 with `loc_addr` equal to the address.
- R3: A write to 0xFF50 while `boot_active` is 1 clears it from the next cycle on, whatever the data. Nothing sets it again before reset, including a further write to 0xFF50.
- R4: While booting, a write to 0x0000–0x0FFF gives `mbc_wr`=0, and a write to 0x1000–0x7FFF gives `mbc_wr`=1.
- R5: After boot exit, every write to 0x0000–0x7FFF gives `mbc_wr`=1.
- R6: 0x8000–0x9FFF selects bit 2 with `loc_addr` = address AND 0x1FFF.
- R7: 0xA000–0xBFFF selects bit 3 with `loc_addr` = address AND 0x1FFF.
- R8: 0xC000–0xDFFF and its mirror 0xE000–0xFDFF both select bit 4 with `loc_addr` = address AND 0x1FFF. A write through either window is read back through the other.
- R9: 0xFE00–0xFEFF selects bit 5 with `loc_addr` = address AND 0xFF. It is distinct from the work RAM mirror.
- R10: 0xFF00–0xFF7F selects bit 6 and 0xFF80–0xFFFF selects bit 7, both with `loc_addr` = address AND 0x7F.
- R11: `mem_wr` equals `cpu_wr` for addresses 0x8000–0xFFFF and is 0 below 0x8000. `mbc_wr` and `mem_wr` are never both 1.
- R12: With the default read latency of 1, `cpu_rdata` in the cycle after an address equals the data that the region selected for that address returns in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data, passed to the targets |
| rgn_sel | output | 8 | One-hot region select |
| loc_addr | output | 16 | Offset inside the selected region |
| mem_wr | output | 1 | Write strobe for RAM, object, I/O and high-RAM targets |
| mbc_wr | output | 1 | Command write to the bank controller |
| tgt_wdata | output | 8 | Write data to the targets |
| boot_active | output | 1 | Boot overlay flag |
| cart_rdata | input | 8 | Cartridge read data |
| vram_rdata | input | 8 | Video RAM read data |
| xram_rdata | input | 8 | External RAM read data |
| wram_rdata | input | 8 | Work RAM read data |
| oam_rdata | input | 8 | Object attribute read data |
| io_rdata | input | 8 | I/O page read data |
| hram_rdata | input | 8 | High RAM read data |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The boot flag is the only long-lived state. If it is wrong, the region select for 0x0000–0x00FF and the `mbc_wr` gate for the low 4 KB show it in the same cycle as the next access there. A stale registered region choice shows up one cycle after the access, as read data from the wrong memory. Because of this, the reference model compares the select, offset and strobes on every access and the read data on the following cycle. It sweeps addresses across the whole map, so that a misplaced window boundary appears at its first crossing.

// File: rtl/sysmap_pkg.sv
package sysmap_pkg;

   localparam int NUM_RGN = 8;

   typedef enum logic [2:0] {
      RGN_BOOT = 3'd0,
      RGN_CART = 3'd1,
      RGN_VRAM = 3'd2,
      RGN_XRAM = 3'd3,
      RGN_WRAM = 3'd4,
      RGN_OAM  = 3'd5,
      RGN_IO   = 3'd6,
      RGN_HRAM = 3'd7
   } rgn_e;

   // computed boot image: affine byte sequence mixed with a nibble swap
   function automatic logic [7:0] boot_byte(input logic [7:0] idx);
      logic [7:0] m;
      m = idx * 8'd37 + 8'h5B;
      return m ^ {idx[3:0], idx[7:4]};
   endfunction

endpackage

// File: rtl/sysmap_region_dec.sv
module sysmap_region_dec
   import sysmap_pkg::*;
#(
   parameter int AW         = 16,
   parameter int BOOT_BYTES = 256
) (
   input  logic [AW-1:0] addr,
   input  logic          boot,
   output rgn_e          rgn,
   output logic [AW-1:0] loc
);
   localparam logic [AW-1:0] BOOT_MASK  = AW'(BOOT_BYTES - 1);
   localparam logic [AW-1:0] WIN8K_MASK = AW'(16'h1FFF);
   localparam logic [AW-1:0] PAGE_MASK  = AW'(16'h00FF);
   localparam logic [AW-1:0] SMALL_MASK = AW'(16'h007F);

   always_comb begin
      rgn = RGN_CART;
      loc = addr;
      if (boot && (addr < AW'(BOOT_BYTES))) begin
         rgn = RGN_BOOT;
         loc = addr & BOOT_MASK;
      end else if (!addr[15]) begin
         rgn = RGN_CART;
         loc = addr;
      end else begin
         unique case (addr[15:13])
            3'b100: begin rgn = RGN_VRAM; loc = addr & WIN8K_MASK; end
            3'b101: begin rgn = RGN_XRAM; loc = addr & WIN8K_MASK; end
            3'b110: begin rgn = RGN_WRAM; loc = addr & WIN8K_MASK; end
            default: begin
               if (addr[12:9] != 4'hF) begin
                  rgn = RGN_WRAM;
                  loc = addr & WIN8K_MASK;
               end else if (!addr[8]) begin
                  rgn = RGN_OAM;
                  loc = addr & PAGE_MASK;
               end else if (addr[7]) begin
                  rgn = RGN_HRAM;
                  loc = addr & SMALL_MASK;
               end else begin
                  rgn = RGN_IO;
                  loc = addr & SMALL_MASK;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/sysmap_boot_ctl.sv
module sysmap_boot_ctl
   import sysmap_pkg::*;
#(
   parameter int          AW         = 16,
   parameter int          BOOT_BYTES = 256,
   parameter logic [15:0] EXIT_ADDR  = 16'hFF50
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   output logic          boot,
   output logic [7:0]    boot_data
);
   localparam logic [AW-1:0] IDX_MASK = AW'(BOOT_BYTES - 1);

   logic boot_q;
   logic exit_hit;

   assign exit_hit = wr && (addr == AW'(EXIT_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        boot_q <= 1'b1;
      else if (exit_hit) boot_q <= 1'b0;
   end

   assign boot      = boot_q;
   assign boot_data = boot_byte(8'(addr & IDX_MASK));
endmodule

// File: rtl/sysmap_rd_mux.sv
module sysmap_rd_mux #(
   parameter int NSRC = 8,
   parameter int DW   = 8
) (
   input  logic [NSRC-1:0]         sel,
   input  logic [NSRC-1:0][DW-1:0] src,
   output logic [DW-1:0]           dout
);
   always_comb begin
      dout = '0;
      for (int k = 0; k < NSRC; k++) begin
         dout = dout | (src[k] & {DW{sel[k]}});
      end
   end
endmodule

// File: rtl/sysmap_decoder.sv
module sysmap_decoder
   import sysmap_pkg::*;
#(
   parameter int          DATA_W     = 8,
   parameter int          BOOT_BYTES = 256,
   parameter int          RD_LAT     = 1,
   parameter logic [15:0] EXIT_ADDR  = 16'hFF50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [7:0]        rgn_sel,
   output logic [15:0]       loc_addr,
   output logic              mem_wr,
   output logic              mbc_wr,
   output logic [DATA_W-1:0] tgt_wdata,
   output logic              boot_active,
   input  logic [DATA_W-1:0] cart_rdata,
   input  logic [DATA_W-1:0] vram_rdata,
   input  logic [DATA_W-1:0] xram_rdata,
   input  logic [DATA_W-1:0] wram_rdata,
   input  logic [DATA_W-1:0] oam_rdata,
   input  logic [DATA_W-1:0] io_rdata,
   input  logic [DATA_W-1:0] hram_rdata,
   output logic [DATA_W-1:0] cpu_rdata
);
   localparam int AW         = 16;
   localparam int BOOT_AW    = $clog2(BOOT_BYTES);
   localparam int GUARD_TOP  = 16'h1000;

   // elaboration checks
   if (DATA_W != 8) begin : g_bad_dw
      $error("sysmap_decoder: DATA_W must be 8");
   end
   if (BOOT_BYTES < 2 || BOOT_BYTES > 256 || (1 << BOOT_AW) != BOOT_BYTES) begin : g_bad_boot
      $error("sysmap_decoder: BOOT_BYTES must be a power of two in 2..256");
   end
   if (RD_LAT != 0 && RD_LAT != 1) begin : g_bad_lat
      $error("sysmap_decoder: RD_LAT must be 0 or 1");
   end
   if (EXIT_ADDR[15:8] != 8'hFF || EXIT_ADDR[7]) begin : g_bad_exit
      $error("sysmap_decoder: EXIT_ADDR must lie in the I/O page");
   end

   rgn_e                 rgn;
   logic [AW-1:0]        loc;
   logic                 boot;
   logic [7:0]           boot_data;
   logic [NUM_RGN-1:0]   sel_now;
   logic [NUM_RGN-1:0]   sel_rd;
   logic [DATA_W-1:0]    boot_rd;
   logic [NUM_RGN-1:0][DATA_W-1:0] src;

   sysmap_boot_ctl #(
      .AW(AW), .BOOT_BYTES(BOOT_BYTES), .EXIT_ADDR(EXIT_ADDR)
   ) u_boot (
      .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wr(cpu_wr),
      .boot(boot), .boot_data(boot_data)
   );

   sysmap_region_dec #(
      .AW(AW), .BOOT_BYTES(BOOT_BYTES)
   ) u_dec (
      .addr(cpu_addr), .boot(boot), .rgn(rgn), .loc(loc)
   );

   // one-hot expansion of the region index
   for (genvar g = 0; g < NUM_RGN; g++) begin : g_onehot
      assign sel_now[g] = (rgn == rgn_e'(g));
   end

   // read-path latency variant
   if (RD_LAT == 1) begin : g_rd_reg
      logic [NUM_RGN-1:0] sel_q;
      logic [DATA_W-1:0]  boot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q  <= '0;
            boot_q <= '0;
         end else begin
            sel_q  <= sel_now;
            boot_q <= boot_data;
         end
      end
      assign sel_rd  = sel_q;
      assign boot_rd = boot_q;
   end else begin : g_rd_comb
      assign sel_rd  = sel_now;
      assign boot_rd = boot_data;
   end

   assign src[RGN_BOOT] = boot_rd;
   assign src[RGN_CART] = cart_rdata;
   assign src[RGN_VRAM] = vram_rdata;
   assign src[RGN_XRAM] = xram_rdata;
   assign src[RGN_WRAM] = wram_rdata;
   assign src[RGN_OAM]  = oam_rdata;
   assign src[RGN_IO]   = io_rdata;
   assign src[RGN_HRAM] = hram_rdata;

   sysmap_rd_mux #(
      .NSRC(NUM_RGN), .DW(DATA_W)
   ) u_mux (
      .sel(sel_rd), .src(src), .dout(cpu_rdata)
   );

   assign rgn_sel     = sel_now;
   assign loc_addr    = loc;
   assign boot_active = boot;
   assign tgt_wdata   = cpu_wdata;
   assign mem_wr      = cpu_wr && cpu_addr[15];
   assign mbc_wr      = cpu_wr && !cpu_addr[15] &&
                        !(boot && ({16'h0, cpu_addr} < 32'(GUARD_TOP)));
endmodule

// File: rtl/sysmap_decoder_chk.sv
module sysmap_decoder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] cpu_addr,
   input logic        cpu_wr,
   input logic [7:0]  rgn_sel,
   input logic [15:0] loc_addr,
   input logic        mem_wr,
   input logic        mbc_wr,
   input logic        boot_active
);
   AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rgn_sel) == 1); // R2

   AST_BOOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_active && cpu_wr && cpu_addr == 16'hFF50) |=> !boot_active); // R3

   AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_active |=> !boot_active); // R3

   AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_active && cpu_addr[15:12] == 4'h0) |-> !mbc_wr); // R4

   AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mbc_wr && mem_wr)); // R11

   AST_ROM_NO_MEMWR: assert property (@(posedge clk) disable iff (!rst_n)
      (rgn_sel[0] || rgn_sel[1]) |-> !mem_wr); // R11

   AST_WRAM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_sel[4] |-> (loc_addr[15:13] == 3'b000)); // R8

   AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (rgn_sel[6] || rgn_sel[7]) |-> (loc_addr[15:7] == 9'h0)); // R10
endmodule

bind sysmap_decoder sysmap_decoder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
   .rgn_sel(rgn_sel), .loc_addr(loc_addr), .mem_wr(mem_wr),
   .mbc_wr(mbc_wr), .boot_active(boot_active)
);

// File: tb/sysmap_decoder_tb.sv
module sysmap_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  rgn_sel;
   logic [15:0] loc_addr;
   logic        mem_wr, mbc_wr, boot_active;
   logic [7:0]  tgt_wdata, cpu_rdata;
   logic [7:0]  cart_rdata, vram_rdata, xram_rdata, wram_rdata;
   logic [7:0]  oam_rdata, io_rdata, hram_rdata;

   always #5 clk = ~clk;

   sysmap_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .rgn_sel(rgn_sel), .loc_addr(loc_addr),
      .mem_wr(mem_wr), .mbc_wr(mbc_wr), .tgt_wdata(tgt_wdata),
      .boot_active(boot_active), .cart_rdata(cart_rdata),
      .vram_rdata(vram_rdata), .xram_rdata(xram_rdata),
      .wram_rdata(wram_rdata), .oam_rdata(oam_rdata), .io_rdata(io_rdata),
      .hram_rdata(hram_rdata), .cpu_rdata(cpu_rdata)
   );

   // target memories, driven by the DUT's outputs
   logic [7:0] m_vram [8192];
   logic [7:0] m_xram [8192];
   logic [7:0] m_wram [8192];
   logic [7:0] m_oam  [256];
   logic [7:0] m_io   [128];
   logic [7:0] m_hram [128];

   function automatic logic [7:0] cart_pat(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   always @(posedge clk) begin
      if (mem_wr) begin
         if (rgn_sel[2]) m_vram[loc_addr[12:0]] <= tgt_wdata;
         if (rgn_sel[3]) m_xram[loc_addr[12:0]] <= tgt_wdata;
         if (rgn_sel[4]) m_wram[loc_addr[12:0]] <= tgt_wdata;
         if (rgn_sel[5]) m_oam[loc_addr[7:0]]   <= tgt_wdata;
         if (rgn_sel[6]) m_io[loc_addr[6:0]]    <= tgt_wdata;
         if (rgn_sel[7]) m_hram[loc_addr[6:0]]  <= tgt_wdata;
      end
      cart_rdata <= cart_pat(loc_addr);
      vram_rdata <= m_vram[loc_addr[12:0]];
      xram_rdata <= m_xram[loc_addr[12:0]];
      wram_rdata <= m_wram[loc_addr[12:0]];
      oam_rdata  <= m_oam[loc_addr[7:0]];
      io_rdata   <= m_io[loc_addr[6:0]];
      hram_rdata <= m_hram[loc_addr[6:0]];
   end

   // reference model state
   logic [7:0] r_vram [8192];
   logic [7:0] r_xram [8192];
   logic [7:0] r_wram [8192];
   logic [7:0] r_oam  [256];
   logic [7:0] r_io   [128];
   logic [7:0] r_hram [128];
   int  ref_boot;
   int  total = 0;
   int  bad = 0;
   int  pend_rd = 0;
   int  pend_exp = 0;
   string pend_req = "";
   bit  done = 0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int boot_ref(input int i);
      int m;
      m = (i * 37 + 91) % 256;
      return m ^ (((i % 16) * 16) + (i / 16));
   endfunction

   // expected region index and offset, per the requirements
   task automatic expect_map(input int a, output int r, output int off, output string req);
      if (ref_boot != 0 && a < 256)  begin r = 0; off = a;          req = "R2"; end
      else if (a < 32768)            begin r = 1; off = a;          req = "R2"; end
      else if (a < 40960)            begin r = 2; off = a % 8192;   req = "R6"; end
      else if (a < 49152)            begin r = 3; off = a % 8192;   req = "R7"; end
      else if (a < 65024)            begin r = 4; off = a % 8192;   req = "R8"; end
      else if (a < 65280)            begin r = 5; off = a % 256;    req = "R9"; end
      else                           begin r = (a < 65408) ? 6 : 7; off = a % 128; req = "R10"; end
   endtask

   task automatic op(input int a, input bit wr, input int d);
      int r, off, exp_mbc, exp_mem, rv;
      string req;
      @(negedge clk);
      if (pend_rd != 0) chk({pend_req, "/R12 rdata"}, int'(cpu_rdata), pend_exp);
      cpu_addr = 16'(a); cpu_wr = wr; cpu_wdata = 8'(d);
      #1;
      chk("R3 boot flag", int'(boot_active), ref_boot);
      expect_map(a, r, off, req);
      chk({req, " region"}, int'(rgn_sel), 1 << r);
      chk({req, " offset"}, int'(loc_addr), off);
      exp_mem = (wr && a >= 32768) ? 1 : 0;
      if (!wr || a >= 32768) exp_mbc = 0;
      else if (ref_boot != 0 && a < 4096) exp_mbc = 0;
      else exp_mbc = 1;
      chk((ref_boot != 0) ? "R4 mbc_wr" : "R5 mbc_wr", int'(mbc_wr), exp_mbc);
      chk("R11 mem_wr", int'(mem_wr), exp_mem);
      if (wr) begin
         pend_rd = 0;
         case (r)
            2: r_vram[off] = 8'(d);
            3: r_xram[off] = 8'(d);
            4: r_wram[off] = 8'(d);
            5: r_oam[off]  = 8'(d);
            6: r_io[off]   = 8'(d);
            7: r_hram[off] = 8'(d);
            default: ;
         endcase
         if (a == 16'hFF50) ref_boot = 0;
      end else begin
         case (r)
            0: rv = boot_ref(off);
            1: rv = int'(cart_pat(16'(off)));
            2: rv = int'(r_vram[off]);
            3: rv = int'(r_xram[off]);
            4: rv = int'(r_wram[off]);
            5: rv = int'(r_oam[off]);
            6: rv = int'(r_io[off]);
            default: rv = int'(r_hram[off]);
         endcase
         pend_rd = 1; pend_exp = rv;
         pend_req = (r == 0) ? "R1" : req;
      end
   endtask

   initial begin
      for (int i = 0; i < 8192; i++) begin
         m_vram[i] = 8'(i); r_vram[i] = 8'(i);
         m_xram[i] = 8'(i ^ 85); r_xram[i] = 8'(i ^ 85);
         m_wram[i] = 8'(i * 3); r_wram[i] = 8'(i * 3);
      end
      for (int i = 0; i < 256; i++) begin m_oam[i] = 8'(255 - i); r_oam[i] = 8'(255 - i); end
      for (int i = 0; i < 128; i++) begin
         m_io[i] = 8'(i + 16); r_io[i] = 8'(i + 16);
         m_hram[i] = 8'(i ^ 170); r_hram[i] = 8'(i ^ 170);
      end
   end

   initial begin
      ref_boot = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset flag", int'(boot_active), 1);
      // boot overlay reads
      op(16'h0000, 0, 0); op(16'h0001, 0, 0); op(16'h007F, 0, 0);
      op(16'h00FF, 0, 0); op(16'h0100, 0, 0); op(16'h7FFF, 0, 0);
      // command writes under the boot guard
      op(16'h0005, 1, 8'h0A); op(16'h0FFF, 1, 8'h01);
      op(16'h1000, 1, 8'h02); op(16'h2000, 1, 8'h03);
      // RAM windows
      op(16'h8000, 1, 8'h11); op(16'h8000, 0, 0); op(16'h9FFF, 1, 8'h22); op(16'h9FFF, 0, 0);
      op(16'hA123, 1, 8'h33); op(16'hA123, 0, 0); op(16'hBFFF, 0, 0);
      op(16'hC010, 1, 8'h44); op(16'hE010, 0, 0);
      op(16'hFDFF, 1, 8'h55); op(16'hDDFF, 0, 0); op(16'hC000, 0, 0);
      op(16'hFE00, 1, 8'h66); op(16'hFE00, 0, 0); op(16'hDE00, 0, 0);
      op(16'hFEFF, 0, 0); op(16'hFF00, 0, 0);
      op(16'hFF7F, 1, 8'h77); op(16'hFF7F, 0, 0);
      op(16'hFF80, 1, 8'h88); op(16'hFF80, 0, 0); op(16'hFFFF, 0, 0);
      // boot exit and its one-shot nature
      op(16'hFF50, 1, 8'h00); op(16'h0000, 0, 0); op(16'h00FF, 0, 0);
      op(16'h0005, 1, 8'h0A); op(16'h0FFF, 1, 8'h00);
      op(16'hFF50, 1, 8'h01); op(16'h0010, 0, 0);
      // sweep across the map
      for (int a = 3; a < 65536; a += 257) op(a, 0, 0);
      for (int a = 32768; a < 65536; a += 509) op(a, 1, a % 256);
      for (int a = 32769; a < 65536; a += 509) op(a - 1, 0, 0);
      op(16'h0000, 0, 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule